// File: doc/BRIEF.md
# Memory Bank Sizing and Decode

This block holds the bank layout of a memory subsystem with six module sockets, each empty, holding an 8 MB module or holding a 32 MB module. Strap inputs report what each socket holds. Firmware reads the straps through two read-only byte registers on an 8-bit I/O port bus. It then lays out the banks by writing an eight-slot table of end addresses, counted in 8 MB pages. Reading that table back walks it through an auto-incrementing index, and reading the presence register rewinds the index. A fourth port reports a fixed "no parity error" status.

Socket n covers the pages from slot n up to, but not including, slot n+1. Socket 0 always starts at page 0. The decode half compares the page number of a CPU physical address, which is address bits [27:23], against each populated socket's range. It drives a one-hot socket select and a hit flag.

After reset the table is all zero. If the auto-configure input is high, the first clock after reset release loads the table so that the populated sockets sit back to back from page 0.

Top module: `memcfg_ctrl`

## Requirements
- R1: A read at port 0x803 returns bit n = 1 exactly when socket n is populated with a 32 MB module; bits 7:6 read 0.
- R2: A read at port 0x804 returns 0xFF with bit n cleared for every populated socket n (active-low presence).
- R3: Any read of port 0x804 sets the table read index to 0, so the next read of port 0x820 returns slot 0.
- R4: A write to port 0x820 stores data bits 4:0 into the table slot given by data bits 7:5.
- R5: A read of port 0x820 returns, in bits 4:0, the slot at the current index with bits 7:5 zero. The index then advances by one and wraps from 7 to 0.
- R6: A read of port 0x841 always returns 0x01.
- R7: Reads at any other port address return 0xFF. Writes to any port other than 0x820 leave the table unchanged.
- R8: Socket n (n = 0..5) is selected when it is populated and start <= page < end. Here end is slot n+1, start is slot n for n > 0, and start is 0 for socket 0.
- R9: An unpopulated socket, or a socket whose end is not above its start, is never selected.
- R10: At most one select bit is high. When several ranges contain the page, the highest socket number wins. The hit flag is high exactly when a select is high.
- R11: Reset with auto-configure low leaves all eight slots and the read index at 0.
- R12: With auto-configure high, the first clock after reset release sets slot 0 and slot 7 to 0. It also sets slot n+1 to the running total of module sizes, in 8 MB pages (32 MB = 4, 8 MB = 1), over the populated sockets 0..n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| autocfg | input | 1 | Load a packed layout into the table on the first clock after reset |
| strap_present | input | 6 | Bit n high: socket n holds a module |
| strap_large | input | 6 | Bit n high: the module in socket n is 32 MB (else 8 MB) |
| io_addr | input | 12 | I/O port address |
| io_rd | input | 1 | Read strobe; read side effects occur at the clock edge |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid while io_rd is high |
| cpu_page | input | 5 | CPU physical address bits [27:23] (8 MB page number) |
| bank_sel | output | 6 | One-hot socket select |
| bank_hit | output | 1 | High when some socket is selected |

## Verification
A corrupted table slot shows up on bank_sel at once, for every page near that socket's boundary. It also shows up on the next read of port 0x820 that reaches that slot, so a full read-back after a presence read exposes it within eight reads. A wrong read index shows as a shifted read-back sequence from the first read of port 0x820 after the presence read. A bad auto-configure load shows in the first read-back after reset release. Each of the 729 strap combinations is checked against an arithmetic packing model, and random tables are swept over all 32 pages.

// File: rtl/memcfg_pkg.sv
package memcfg_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    PSEL_NONE,
    PSEL_ID,
    PSEL_PRES,
    PSEL_SIZE,
    PSEL_PAR
  } port_sel_e;
endpackage

// File: rtl/memcfg_regs.sv
module memcfg_regs #(
  parameter int unsigned NUM_SOCK = 6,
  parameter int unsigned END_W    = 5,
  parameter int unsigned IO_AW    = 12,
  parameter int unsigned UNIT_MB  = 8,
  parameter int unsigned BIG_MB   = 32,
  parameter int unsigned SMALL_MB = 8,
  parameter logic [IO_AW-1:0] ADDR_ID   = 12'h803,
  parameter logic [IO_AW-1:0] ADDR_PRES = 12'h804,
  parameter logic [IO_AW-1:0] ADDR_SIZE = 12'h820,
  parameter logic [IO_AW-1:0] ADDR_PAR  = 12'h841,
  localparam int unsigned NSLOT  = NUM_SOCK + 2,
  localparam int unsigned SLOT_W = $clog2(NSLOT),
  localparam int unsigned BW     = memcfg_pkg::BYTE_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   autocfg,
  input  logic [NUM_SOCK-1:0]    strap_present,
  input  logic [NUM_SOCK-1:0]    strap_large,
  input  logic [IO_AW-1:0]       io_addr,
  input  logic                   io_rd,
  input  logic                   io_wr,
  input  logic [BW-1:0]          io_wdata,
  output logic [BW-1:0]          io_rdata,
  output logic [NSLOT*END_W-1:0] tab_flat
);
  import memcfg_pkg::*;

  localparam int unsigned FLD_W    = BW - END_W;
  localparam int unsigned BIG_PG   = BIG_MB / UNIT_MB;
  localparam int unsigned SMALL_PG = SMALL_MB / UNIT_MB;

  port_sel_e          psel;
  logic [END_W-1:0]   tab_q [NSLOT];
  logic [END_W-1:0]   tab_d [NSLOT];
  logic [END_W-1:0]   pack  [NSLOT];
  logic [SLOT_W-1:0]  idx_q, idx_d;
  logic               init_q;
  logic               tab_en, idx_en, wr_hit;
  logic [FLD_W-1:0]   wr_slot;

  // Port decode
  always_comb begin
    case (io_addr)
      ADDR_ID:   psel = PSEL_ID;
      ADDR_PRES: psel = PSEL_PRES;
      ADDR_SIZE: psel = PSEL_SIZE;
      ADDR_PAR:  psel = PSEL_PAR;
      default:   psel = PSEL_NONE;
    endcase
  end

  // Packed layout for auto-configure
  always_comb begin
    logic [END_W-1:0] cum;
    cum = '0;
    pack[0] = '0;
    pack[NSLOT-1] = '0;
    for (int n = 0; n < NUM_SOCK; n++) begin
      if (strap_present[n])
        cum = cum + (strap_large[n] ? END_W'(BIG_PG) : END_W'(SMALL_PG));
      pack[n+1] = cum;
    end
  end

  assign wr_slot = io_wdata[BW-1:END_W];
  assign wr_hit  = init_q && io_wr && (psel == PSEL_SIZE) && (int'(wr_slot) < NSLOT);
  assign tab_en  = (!init_q && autocfg) || wr_hit;
  assign idx_en  = io_rd && ((psel == PSEL_PRES) || (psel == PSEL_SIZE));

  // Next state
  always_comb begin
    tab_d = tab_q;
    idx_d = idx_q;
    if (!init_q) begin
      if (autocfg) tab_d = pack;
    end else if (wr_hit) begin
      tab_d[SLOT_W'(wr_slot)] = io_wdata[END_W-1:0];
    end
    if (psel == PSEL_PRES)
      idx_d = '0;
    else if (idx_q == SLOT_W'(NSLOT - 1))
      idx_d = '0;
    else
      idx_d = idx_q + 1'b1;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < NSLOT; n++) tab_q[n] <= '0;
      idx_q  <= '0;
      init_q <= 1'b0;
    end else begin
      init_q <= 1'b1;
      if (tab_en) tab_q <= tab_d;
      if (idx_en) idx_q <= idx_d;
    end
  end

  // Read data
  always_comb begin
    case (psel)
      PSEL_ID:   io_rdata = BW'(strap_present & strap_large);
      PSEL_PRES: io_rdata = ~BW'(strap_present);
      PSEL_SIZE: io_rdata = BW'(tab_q[idx_q]);
      PSEL_PAR:  io_rdata = BW'(1);
      default:   io_rdata = '1;
    endcase
  end

  always_comb begin
    for (int n = 0; n < NSLOT; n++) tab_flat[n*END_W +: END_W] = tab_q[n];
  end
endmodule

// File: rtl/memcfg_bankcmp.sv
module memcfg_bankcmp #(
  parameter int unsigned NUM_SOCK = 6,
  parameter int unsigned END_W    = 5,
  localparam int unsigned NSLOT   = NUM_SOCK + 2
) (
  input  logic [NSLOT*END_W-1:0] tab_flat,
  input  logic [NUM_SOCK-1:0]    strap_present,
  input  logic [END_W-1:0]       page,
  output logic [NUM_SOCK-1:0]    match
);
  for (genvar g = 0; g < NUM_SOCK; g++) begin : g_sock
    logic [END_W-1:0] lo, hi;
    if (g == 0) begin : g_first
      assign lo = '0;
    end else begin : g_rest
      assign lo = tab_flat[g*END_W +: END_W];
    end
    assign hi = tab_flat[(g+1)*END_W +: END_W];
    assign match[g] = strap_present[g] && (page >= lo) && (page < hi);
  end
endmodule

// File: rtl/memcfg_prio.sv
module memcfg_prio #(
  parameter int unsigned NUM_SOCK = 6
) (
  input  logic [NUM_SOCK-1:0] match,
  output logic [NUM_SOCK-1:0] sel,
  output logic                hit
);
  always_comb begin
    sel = '0;
    for (int n = 0; n < NUM_SOCK; n++) begin
      if (match[n]) begin
        sel    = '0;
        sel[n] = 1'b1;
      end
    end
    hit = |match;
  end
endmodule

// File: rtl/memcfg_ctrl.sv
module memcfg_ctrl #(
  parameter int unsigned NUM_SOCK = 6,
  parameter int unsigned END_W    = 5,
  parameter int unsigned IO_AW    = 12,
  parameter logic [IO_AW-1:0] ADDR_ID   = 12'h803,
  parameter logic [IO_AW-1:0] ADDR_PRES = 12'h804,
  parameter logic [IO_AW-1:0] ADDR_SIZE = 12'h820,
  parameter logic [IO_AW-1:0] ADDR_PAR  = 12'h841,
  localparam int unsigned NSLOT = NUM_SOCK + 2,
  localparam int unsigned BW    = memcfg_pkg::BYTE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                autocfg,
  input  logic [NUM_SOCK-1:0] strap_present,
  input  logic [NUM_SOCK-1:0] strap_large,
  input  logic [IO_AW-1:0]    io_addr,
  input  logic                io_rd,
  input  logic                io_wr,
  input  logic [BW-1:0]       io_wdata,
  output logic [BW-1:0]       io_rdata,
  input  logic [END_W-1:0]    cpu_page,
  output logic [NUM_SOCK-1:0] bank_sel,
  output logic                bank_hit
);
  logic [1:0]               rst_ff;
  logic                     rst_int_n;
  logic [NSLOT*END_W-1:0]   tab_flat;
  logic [NUM_SOCK-1:0]      match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= '0;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_int_n = rst_ff[1];

  memcfg_regs #(
    .NUM_SOCK(NUM_SOCK), .END_W(END_W), .IO_AW(IO_AW),
    .ADDR_ID(ADDR_ID), .ADDR_PRES(ADDR_PRES),
    .ADDR_SIZE(ADDR_SIZE), .ADDR_PAR(ADDR_PAR)
  ) u_regs (
    .clk(clk), .rst_n(rst_int_n), .autocfg(autocfg),
    .strap_present(strap_present), .strap_large(strap_large),
    .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .tab_flat(tab_flat)
  );

  memcfg_bankcmp #(.NUM_SOCK(NUM_SOCK), .END_W(END_W)) u_cmp (
    .tab_flat(tab_flat), .strap_present(strap_present),
    .page(cpu_page), .match(match)
  );

  memcfg_prio #(.NUM_SOCK(NUM_SOCK)) u_prio (
    .match(match), .sel(bank_sel), .hit(bank_hit)
  );
endmodule

// File: rtl/memcfg_chk.sv
module memcfg_chk #(
  parameter int unsigned NUM_SOCK = 6,
  parameter int unsigned IO_AW    = 12,
  parameter int unsigned SLOT_W   = 3,
  parameter logic [IO_AW-1:0] ADDR_ID   = 12'h803,
  parameter logic [IO_AW-1:0] ADDR_PRES = 12'h804,
  parameter logic [IO_AW-1:0] ADDR_SIZE = 12'h820,
  parameter logic [IO_AW-1:0] ADDR_PAR  = 12'h841
) (
  input logic                clk,
  input logic                rst_n,
  input logic [IO_AW-1:0]    io_addr,
  input logic                io_rd,
  input logic [7:0]          io_rdata,
  input logic [NUM_SOCK-1:0] strap_present,
  input logic [NUM_SOCK-1:0] strap_large,
  input logic [NUM_SOCK-1:0] bank_sel,
  input logic                bank_hit,
  input logic [SLOT_W-1:0]   idx
);
  AST_ID_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == ADDR_ID) |-> io_rdata == 8'(strap_present & strap_large)); // R1
  AST_PRES_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == ADDR_PRES) |-> io_rdata == ~8'(strap_present)); // R2
  AST_IDX_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == ADDR_PRES) |=> idx == '0); // R3
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == ADDR_SIZE) |=> idx == SLOT_W'($past(idx) + 1'b1)); // R5
  AST_PAR_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == ADDR_PAR) |-> io_rdata == 8'h01); // R6
  AST_SEL_POPULATED: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_sel & ~strap_present) == '0); // R9
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_sel)); // R10
  AST_HIT_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
    bank_hit == (bank_sel != '0)); // R10
endmodule

bind memcfg_ctrl memcfg_chk #(
  .NUM_SOCK(NUM_SOCK), .IO_AW(IO_AW), .SLOT_W($clog2(NUM_SOCK + 2)),
  .ADDR_ID(ADDR_ID), .ADDR_PRES(ADDR_PRES),
  .ADDR_SIZE(ADDR_SIZE), .ADDR_PAR(ADDR_PAR)
) u_chk (
  .clk(clk), .rst_n(rst_int_n), .io_addr(io_addr), .io_rd(io_rd),
  .io_rdata(io_rdata), .strap_present(strap_present),
  .strap_large(strap_large), .bank_sel(bank_sel), .bank_hit(bank_hit),
  .idx(u_regs.idx_q)
);

// File: tb/test_memcfg_ctrl.sv
module test_memcfg_ctrl;
  localparam logic [11:0] P_ID = 12'h803, P_PRES = 12'h804, P_SIZE = 12'h820, P_PAR = 12'h841;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        autocfg = 1'b0;
  logic [5:0]  strap_present = '0, strap_large = '0;
  logic [11:0] io_addr = '0;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic [4:0]  cpu_page = '0;
  logic [5:0]  bank_sel;
  logic        bank_hit;

  int n_chk = 0, n_fail = 0;
  logic [4:0]  m_tab [8];
  logic [31:0] seed = 32'h1d2c3b4a;
  logic [7:0]  rv;

  always #2 clk = ~clk;

  memcfg_ctrl i_memcfg_ctrl (
    .clk(clk), .rst_n(rst_n), .autocfg(autocfg),
    .strap_present(strap_present), .strap_large(strap_large),
    .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata),
    .cpu_page(cpu_page), .bank_sel(bank_sel), .bank_hit(bank_hit)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic io_read(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic io_write(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic readback(input string tag);
    logic [7:0] d;
    io_read(P_PRES, d);
    for (int k = 0; k < 8; k++) begin
      io_read(P_SIZE, d);
      chk(tag, d, {3'b000, m_tab[k]});
    end
  endtask

  task automatic sweep_pages(input string tag);
    for (int a = 0; a < 32; a++) begin
      logic [5:0] es;
      logic [4:0] lo;
      @(negedge clk);
      cpu_page = 5'(a);
      es = '0;
      for (int n = 0; n < 6; n++) begin
        lo = (n == 0) ? 5'd0 : m_tab[n];
        if (strap_present[n] && a >= int'(lo) && a < int'(m_tab[n+1])) begin
          es = '0; es[n] = 1'b1;
        end
      end
      #1;
      chk(tag, bank_sel, es);
      chk(tag, bank_hit, int'(es != '0));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // Every strap combination with auto-configure: R1 R2 R12 R8
    for (int c = 0; c < 729; c++) begin
      int v, cum;
      v = c; cum = 0;
      for (int n = 0; n < 6; n++) begin
        strap_present[n] = (v % 3) != 0;
        strap_large[n]   = (v % 3) == 2;
        v = v / 3;
        if (strap_present[n]) cum += strap_large[n] ? 4 : 1;
        m_tab[n+1] = 5'(cum);
      end
      m_tab[0] = '0; m_tab[7] = '0;
      autocfg = 1'b1;
      do_reset();
      io_read(P_ID, rv);
      chk("R1 id", rv, {2'b00, strap_present & strap_large});
      io_read(P_PRES, rv);
      chk("R2 presence", rv, {2'b11, ~strap_present});
      readback("R12 packed table");
      sweep_pages("R8 packed decode");
    end

    // Plain reset: R11
    autocfg = 1'b0;
    strap_present = 6'h3f; strap_large = 6'h15;
    do_reset();
    for (int k = 0; k < 8; k++) m_tab[k] = '0;
    readback("R11 reset table");

    // Writes elsewhere ignored, unmapped reads, parity: R7 R6
    io_write(P_ID, 8'he7);
    io_write(P_PRES, 8'h3f);
    io_write(P_PAR, 8'h41);
    io_write(12'h821, 8'h25);
    io_write(12'h7ff, 8'hff);
    readback("R7 ignored writes");
    io_read(12'h805, rv); chk("R7 unmapped", rv, 8'hff);
    io_read(12'h000, rv); chk("R7 unmapped", rv, 8'hff);
    io_read(12'hfff, rv); chk("R7 unmapped", rv, 8'hff);
    io_read(P_PAR, rv);   chk("R6 parity", rv, 8'h01);
    io_write(P_SIZE, 8'h4a);
    io_read(P_PAR, rv);   chk("R6 parity", rv, 8'h01);
    m_tab[2] = 5'd10;

    // Zero-size sockets: R9
    for (int s = 0; s < 8; s++) begin
      io_write(P_SIZE, {3'(s), 5'd5});
      m_tab[s] = 5'd5;
    end
    sweep_pages("R9 zero size");
    strap_present = 6'h3e;
    sweep_pages("R9 unpopulated");

    // Random tables with overlaps: R4 R10 R5 R3
    for (int r = 0; r < 60; r++) begin
      logic [31:0] x;
      x = rnd();
      strap_present = x[5:0] | 6'(r & 1);
      strap_large   = x[11:6];
      for (int s = 0; s < 8; s++) begin
        x = rnd();
        m_tab[s] = x[4:0];
        io_write(P_SIZE, {3'(s), x[4:0]});
      end
      readback("R4 write readback");
      for (int k = 0; k < 3; k++) begin
        io_read(P_SIZE, rv);
        chk("R5 index wrap", rv, {3'b000, m_tab[k]});
      end
      io_read(P_PRES, rv);
      io_read(P_SIZE, rv);
      chk("R3 index rewind", rv, {3'b000, m_tab[0]});
      sweep_pages("R10 priority decode");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule